// File: doc/BRIEF.md
# Reset Cause Register with Flash Access Guard

This block is the reset hub of a small 8-bit microcontroller. It watches three kinds of flash access: instruction fetches, table reads made from data-side code, and flash write or erase requests. It turns any illegal access into a flash error reset. It also takes a software reset strobe and a timeout from an external watchdog counter. Whatever the cause, the block drives one internal system reset pulse. It keeps an 8-bit cause register that tells software why the last reset happened. These internal resets never drive the external reset pin. The pin enters the block only as the asynchronous input `ext_rst_n`.

The sequencer has two states. `ST_RUN` is normal operation, where causes are accepted. `ST_HOLD` is the reset pulse, where causes are ignored. The transition RUN→HOLD is taken on any cause in a clock cycle. It clears the cause register and sets the flag of every cause present in that cycle. The transition HOLD→RUN is taken once the pulse counter has counted `PULSE_LEN` clocks. An external reset forces `ST_HOLD` asynchronously and loads the pin flag.

A watchdog support divider runs beside the sequencer. Every reset turns the watchdog enable on and restarts the divider. While the enable is on, the divider issues one clock-enable tick per `WDT_DIV` system clocks. A one-cycle `wdt_dis` strobe turns the enable off until the next reset.

Top module: `rst_cause_guard`

## Requirements
- R1: An instruction fetch (`fetch_vld`) to an address above 0x7BFF causes a flash error reset. A fetch at 0x7BFF or below has no effect.
- R2: A table read (`tblrd_vld`) to an address above 0x7BFF causes a flash error reset.
- R3: A flash write/erase (`fwr_vld`) above 0x7BFF causes a flash error reset only while `pswe` is 1. With `pswe` at 0, the request leaves `sys_rst` and `rst_src` unchanged.
- R4: While `sec_lock` is 1, a table read at any address, or a flash write/erase with `pswe` at 1, causes a flash error reset.
- R5: A flash write/erase with `pswe` at 1 while `vdd_mon_en` is 0 causes a flash error reset, even at a legal address.
- R6: A `sw_rst_req` strobe causes a reset, after which `rst_src` reads 0x10 (bit 4).
- R7: A `wdt_expire` strobe causes a reset, after which `rst_src` reads 0x20 (bit 5).
- R8: A cause seen at a clock edge in run mode raises `sys_rst` at that same edge for exactly 4 clocks. `rst_src` is loaded at the same edge: bit 6 is flash error, bit 5 watchdog, bit 4 software, bit 0 pin. All other bits read 0, and every flag not caused by this reset is cleared.
- R9: Several causes in one cycle set all their flags and produce one single 4-clock pulse.
- R10: Causes arriving while `sys_rst` is high are ignored. `rst_src` is unchanged and no extra pulse follows.
- R11: `sys_rst` is high while `ext_rst_n` is low and for 4 clocks after its release. `rst_src` then reads 0x01.
- R12: After any reset, `wdt_en` is 1 and `wdt_tick` pulses for one clock every 12 clocks. The first tick comes in the 12th clock after `sys_rst` falls. A `wdt_dis` strobe clears `wdt_en`, and no further ticks appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin level, active low, asynchronous |
| fetch_vld | input | 1 | Instruction fetch or branch target valid |
| fetch_addr | input | 16 | Fetch address |
| tblrd_vld | input | 1 | Table read from code space valid |
| tblrd_addr | input | 16 | Table read address |
| fwr_vld | input | 1 | Flash write or erase request valid |
| fwr_addr | input | 16 | Flash write or erase address |
| pswe | input | 1 | Program store write enable |
| sec_lock | input | 1 | Security restriction blocks this access |
| vdd_mon_en | input | 1 | Supply monitor enabled |
| sw_rst_req | input | 1 | Software reset strobe (write 1 to bit 4) |
| wdt_expire | input | 1 | Watchdog timeout strobe |
| wdt_dis | input | 1 | Watchdog disable strobe |
| sys_rst | output | 1 | Internal system reset pulse, active high |
| rst_src | output | 8 | Reset cause register |
| wdt_en | output | 1 | Watchdog enable |
| wdt_tick | output | 1 | Watchdog clock enable, one pulse per 12 clocks |

## Verification
The address checks are tried on both sides of the 0x7BFF boundary for each access kind. This separates an off-by-one limit from a correct one, and a wrong access kind from the right one. Flash writes are tried with and without `pswe`, with the security input, and with the supply monitor off, so each qualifier is shown to gate only its own path. Combined causes and causes that arrive during a pulse separate flag merging from flag replacement. They also show whether a second pulse is started. Watchdog ticks are compared against a behavioural model on every clock, before and after the disable strobe.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    typedef enum logic [0:0] {ST_RUN, ST_HOLD} seq_state_t;
    localparam int SRC_W    = 8;
    localparam int BIT_PIN  = 0;
    localparam int BIT_SW   = 4;
    localparam int BIT_WDT  = 5;
    localparam int BIT_FERR = 6;
endpackage

// File: rtl/flash_guard.sv
module flash_guard #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CODE_TOP = 16'h7BFF
) (
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              tblrd_vld,
    input  logic [ADDR_W-1:0] tblrd_addr,
    input  logic              fwr_vld,
    input  logic [ADDR_W-1:0] fwr_addr,
    input  logic              pswe,
    input  logic              sec_lock,
    input  logic              vdd_mon_en,
    output logic              ferr_hit
);
    logic fetch_bad, tbl_bad, wr_bad;

    always_comb begin
        fetch_bad = fetch_vld && (fetch_addr > CODE_TOP);
        tbl_bad   = tblrd_vld && ((tblrd_addr > CODE_TOP) || sec_lock);
        wr_bad    = fwr_vld && pswe &&
                    ((fwr_addr > CODE_TOP) || sec_lock || !vdd_mon_en);
        ferr_hit  = fetch_bad || tbl_bad || wr_bad;
    end
endmodule

// File: rtl/rst_seq.sv
module rst_seq
    import rcg_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             ext_rst_n,
    input  logic             sw_req,
    input  logic             wdt_req,
    input  logic             ferr_req,
    output logic             sys_rst,
    output logic [SRC_W-1:0] rst_src
);
    localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(PULSE_LEN - 1);

    seq_state_t       state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [SRC_W-1:0] src_q, src_d;
    logic             any_cause;

    assign any_cause = sw_req || wdt_req || ferr_req;

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            src_q   <= SRC_W'(1) << BIT_PIN;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            src_q   <= src_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        src_d   = src_q;
        unique case (state_q)
            ST_RUN: begin
                if (any_cause) begin
                    state_d          = ST_HOLD;
                    cnt_d            = '0;
                    src_d            = '0;
                    src_d[BIT_SW]    = sw_req;
                    src_d[BIT_WDT]   = wdt_req;
                    src_d[BIT_FERR]  = ferr_req;
                end
            end
            ST_HOLD: begin
                if (cnt_q == CNT_LAST) state_d = ST_RUN;
                else                   cnt_d   = cnt_q + 1'b1;
            end
        endcase
    end

    assign sys_rst = (state_q == ST_HOLD);
    assign rst_src = src_q;

    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(sys_rst) |=> sys_rst); // R8
    AST_CAUSE_START: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!sys_rst && any_cause) |=> sys_rst); // R9
    AST_HOLD_SRC_STABLE: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (sys_rst && $past(sys_rst)) |-> $stable(rst_src)); // R10
    AST_SRC_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (rst_src & 8'b1000_1110) == 8'h00); // R8
endmodule

// File: rtl/wdt_div.sv
module wdt_div #(
    parameter int WDT_DIV = 12
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic sys_rst,
    input  logic wdt_dis,
    output logic wdt_en,
    output logic wdt_tick
);
    localparam int DW = (WDT_DIV > 1) ? $clog2(WDT_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(WDT_DIV - 1);

    logic [DW-1:0] div_q;
    logic          en_q;

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            en_q  <= 1'b1;
            div_q <= '0;
        end else if (sys_rst) begin
            en_q  <= 1'b1;
            div_q <= '0;
        end else begin
            if (wdt_dis) en_q <= 1'b0;
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        end
    end

    assign wdt_en   = en_q;
    assign wdt_tick = en_q && !sys_rst && (div_q == DIV_LAST);

    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!ext_rst_n)
        wdt_tick |-> wdt_en); // R12
    AST_EN_AFTER_RST: assert property (@(posedge clk) disable iff (!ext_rst_n)
        sys_rst |=> wdt_en); // R12
endmodule

// File: rtl/rst_cause_guard.sv
module rst_cause_guard
    import rcg_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CODE_TOP  = 16'h7BFF,
    parameter int                PULSE_LEN = 4,
    parameter int                WDT_DIV   = 12
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              tblrd_vld,
    input  logic [ADDR_W-1:0] tblrd_addr,
    input  logic              fwr_vld,
    input  logic [ADDR_W-1:0] fwr_addr,
    input  logic              pswe,
    input  logic              sec_lock,
    input  logic              vdd_mon_en,
    input  logic              sw_rst_req,
    input  logic              wdt_expire,
    input  logic              wdt_dis,
    output logic              sys_rst,
    output logic [SRC_W-1:0]  rst_src,
    output logic              wdt_en,
    output logic              wdt_tick
);
    logic ferr_hit;

    flash_guard #(.ADDR_W(ADDR_W), .CODE_TOP(CODE_TOP)) guard_i (
        .fetch_vld  (fetch_vld),
        .fetch_addr (fetch_addr),
        .tblrd_vld  (tblrd_vld),
        .tblrd_addr (tblrd_addr),
        .fwr_vld    (fwr_vld),
        .fwr_addr   (fwr_addr),
        .pswe       (pswe),
        .sec_lock   (sec_lock),
        .vdd_mon_en (vdd_mon_en),
        .ferr_hit   (ferr_hit)
    );

    rst_seq #(.PULSE_LEN(PULSE_LEN)) seq_i (
        .clk       (clk),
        .ext_rst_n (ext_rst_n),
        .sw_req    (sw_rst_req),
        .wdt_req   (wdt_expire),
        .ferr_req  (ferr_hit),
        .sys_rst   (sys_rst),
        .rst_src   (rst_src)
    );

    wdt_div #(.WDT_DIV(WDT_DIV)) div_i (
        .clk       (clk),
        .ext_rst_n (ext_rst_n),
        .sys_rst   (sys_rst),
        .wdt_dis   (wdt_dis),
        .wdt_en    (wdt_en),
        .wdt_tick  (wdt_tick)
    );

    AST_FETCH_HIGH_RESETS: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!sys_rst && fetch_vld && (fetch_addr > CODE_TOP)) |=> (sys_rst && rst_src[BIT_FERR])); // R1
    AST_SW_FLAG: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!sys_rst && sw_rst_req) |=> rst_src[BIT_SW]); // R6
    AST_WDT_FLAG: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!sys_rst && wdt_expire) |=> rst_src[BIT_WDT]); // R7
endmodule

// File: tb/rst_cause_guard_tb.sv
module rst_cause_guard_tb_top;
    logic        clk = 1'b0;
    logic        ext_rst_n = 1'b0;
    logic        fetch_vld = 0, tblrd_vld = 0, fwr_vld = 0;
    logic [15:0] fetch_addr = 0, tblrd_addr = 0, fwr_addr = 0;
    logic        pswe = 0, sec_lock = 0, vdd_mon_en = 1;
    logic        sw_rst_req = 0, wdt_expire = 0, wdt_dis = 0;
    logic        sys_rst, wdt_en, wdt_tick;
    logic [7:0]  rst_src;

    int errors = 0;
    int checks = 0;
    string cur_req = "R11";

    always #5 clk = ~clk;

    rst_cause_guard dut_i (
        .clk(clk), .ext_rst_n(ext_rst_n),
        .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
        .tblrd_vld(tblrd_vld), .tblrd_addr(tblrd_addr),
        .fwr_vld(fwr_vld), .fwr_addr(fwr_addr),
        .pswe(pswe), .sec_lock(sec_lock), .vdd_mon_en(vdd_mon_en),
        .sw_rst_req(sw_rst_req), .wdt_expire(wdt_expire), .wdt_dis(wdt_dis),
        .sys_rst(sys_rst), .rst_src(rst_src), .wdt_en(wdt_en), .wdt_tick(wdt_tick)
    );

    // behavioural reference
    bit         m_hold, old_hold, m_en, c_sw, c_wdt, c_ferr;
    int         m_cnt, m_div;
    logic [7:0] m_src;

    always @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            m_hold = 1; m_cnt = 0; m_src = 8'h01; m_en = 1; m_div = 0;
        end else begin
            old_hold = m_hold;
            if (old_hold) begin m_en = 1; m_div = 0; end
            else begin
                if (wdt_dis) m_en = 0;
                m_div = (m_div == 11) ? 0 : m_div + 1;
            end
            if (!old_hold) begin
                c_sw   = sw_rst_req;
                c_wdt  = wdt_expire;
                c_ferr = (fetch_vld && int'(fetch_addr) > 'h7BFF) ||
                         (tblrd_vld && (int'(tblrd_addr) > 'h7BFF || sec_lock)) ||
                         (fwr_vld && pswe && (int'(fwr_addr) > 'h7BFF || sec_lock || !vdd_mon_en));
                if (c_sw || c_wdt || c_ferr) begin
                    m_hold = 1; m_cnt = 0;
                    m_src = {1'b0, c_ferr, c_wdt, c_sw, 4'b0000};
                end
            end else if (m_cnt == 3) m_hold = 0;
            else m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk(sys_rst === m_hold, "R8", "sys_rst", int'(sys_rst), int'(m_hold));
        chk(rst_src === m_src, cur_req, "rst_src", int'(rst_src), int'(m_src));
        chk(wdt_en === m_en, "R12", "wdt_en", int'(wdt_en), int'(m_en));
        chk(wdt_tick === (m_en && !m_hold && m_div == 11), "R12", "wdt_tick",
            int'(wdt_tick), int'(m_en && !m_hold && m_div == 11));
    end

    task automatic idle();
        fetch_vld = 0; tblrd_vld = 0; fwr_vld = 0; pswe = 0; sec_lock = 0;
        vdd_mon_en = 1; sw_rst_req = 0; wdt_expire = 0; wdt_dis = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // stimulus is already driven; capture one edge then check result
    task automatic fire(input string req, input bit exp_rst, input logic [7:0] exp_src);
        cur_req = req;
        cyc(1);
        idle();
        chk(sys_rst === exp_rst, req, "pulse start", int'(sys_rst), int'(exp_rst));
        chk(rst_src === exp_src, req, "cause flags", int'(rst_src), int'(exp_src));
        cyc(6);
    endtask

    initial begin
        idle();
        cyc(3);
        chk(sys_rst === 1'b1, "R11", "in pin reset", int'(sys_rst), 1);
        ext_rst_n = 1;
        cyc(4);
        chk(sys_rst === 1'b0, "R11", "release after 4", int'(sys_rst), 0);
        chk(rst_src === 8'h01, "R11", "pin flag", int'(rst_src), 8'h01);
        cyc(3);

        fetch_vld = 1; fetch_addr = 16'h7BFF; fire("R1", 0, 8'h01);
        fetch_vld = 1; fetch_addr = 16'h7C00; fire("R1", 1, 8'h40);
        tblrd_vld = 1; tblrd_addr = 16'h7BFF; fire("R2", 0, 8'h40);
        sw_rst_req = 1; fire("R6", 1, 8'h10);
        tblrd_vld = 1; tblrd_addr = 16'h7C00; fire("R2", 1, 8'h40);
        fwr_vld = 1; fwr_addr = 16'hFFFF; pswe = 0; fire("R3", 0, 8'h40);
        wdt_expire = 1; fire("R7", 1, 8'h20);
        fwr_vld = 1; fwr_addr = 16'h7C00; pswe = 1; fire("R3", 1, 8'h40);
        fwr_vld = 1; fwr_addr = 16'h0100; pswe = 1; fire("R3", 0, 8'h40);
        sw_rst_req = 1; fire("R6", 1, 8'h10);
        tblrd_vld = 1; tblrd_addr = 16'h0010; sec_lock = 1; fire("R4", 1, 8'h40);
        sw_rst_req = 1; fire("R6", 1, 8'h10);
        fwr_vld = 1; fwr_addr = 16'h0010; pswe = 1; sec_lock = 1; fire("R4", 1, 8'h40);
        sw_rst_req = 1; fire("R6", 1, 8'h10);
        fwr_vld = 1; fwr_addr = 16'h0200; pswe = 1; vdd_mon_en = 0; fire("R5", 1, 8'h40);

        // R9: three causes together, one 4-clock pulse
        begin
            int hi = 0;
            sw_rst_req = 1; wdt_expire = 1; fetch_vld = 1; fetch_addr = 16'hF000;
            cur_req = "R9";
            cyc(1); idle();
            chk(rst_src === 8'h70, "R9", "merged flags", int'(rst_src), 8'h70);
            for (int i = 0; i < 12; i++) begin
                if (sys_rst) hi++;
                cyc(1);
            end
            chk(hi == 4, "R9", "single pulse length", hi, 4);
        end

        // R10: cause during pulse ignored
        sw_rst_req = 1; cur_req = "R10";
        cyc(1); idle();
        cyc(1); wdt_expire = 1; fetch_vld = 1; fetch_addr = 16'hFFFF;
        cyc(1); idle();
        cyc(6);
        chk(sys_rst === 1'b0, "R10", "no second pulse", int'(sys_rst), 0);
        chk(rst_src === 8'h10, "R10", "flags kept", int'(rst_src), 8'h10);

        // R12: ticks then disable
        begin
            int ticks = 0;
            cur_req = "R12";
            for (int i = 0; i < 36; i++) begin
                if (wdt_tick) ticks++;
                cyc(1);
            end
            chk(ticks == 3, "R12", "tick count in 36 clocks", ticks, 3);
            wdt_dis = 1; cyc(1); idle();
            ticks = 0;
            for (int i = 0; i < 30; i++) begin
                if (wdt_tick) ticks++;
                cyc(1);
            end
            chk(ticks == 0, "R12", "ticks after disable", ticks, 0);
            chk(wdt_en === 1'b0, "R12", "enable cleared", int'(wdt_en), 0);
        end

        // R11 mid-run pin reset restores enable and pin flag
        cur_req = "R11";
        ext_rst_n = 0; cyc(2);
        ext_rst_n = 1; cyc(4);
        chk(rst_src === 8'h01, "R11", "pin flag again", int'(rst_src), 8'h01);
        chk(wdt_en === 1'b1, "R12", "enable after reset", int'(wdt_en), 1);
        cyc(20);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule